// File: doc/BRIEF.md
# Update Cycle Status Controller

This block paces the once-per-second refresh of a real-time clock's time registers. A 1 Hz tick from the frequency divider starts a cycle. The block first raises an in-progress status bit. It holds that bit for a fixed number of 32.768 kHz periods before it pulses the update strobe that advances the time counters. The bit then stays high through the update window itself. Software that polls the status bit and reads it low therefore has at least the lead time to read the time bytes before they can change.

When the update window closes, the in-progress bit drops and a sticky update-ended flag is set. The flag stays set until software pulses the clear strobe. The interrupt request follows the flag, but only when the update-interrupt enable is set and the transfer-inhibit bit is clear. The inhibit bit also suppresses the strobe to the time counters. The in-progress sequence and the flag still run as normal while inhibit is set. All inputs and outputs are plain control and status pins: no data streams in or out, so there is no valid/ready handshake. Everything runs in one system clock domain, and the slow time base arrives as one-cycle enable pulses.

Top module: `upd_cycle_ctl`

## Requirements
- R1: While rst_n is 0 and in the first cycle after it, busy, cnt_strobe, done_flag and irq are all 0.
- R2: A sec_tick pulse seen while busy is 0 makes busy read 1 from the next clock cycle on.
- R3: cnt_strobe is a single-cycle pulse. It appears in the cycle after the LEAD_TICKS-th slow_tick counted while busy is 1. busy stays 1 for that whole lead period.
- R4: busy stays 1 after the strobe point until UPD_TICKS further slow_tick pulses have been seen. It reads 0 from the next cycle, and done_flag reads 1 in that same cycle.
- R5: done_flag is sticky. It clears in the cycle after a flag_clr pulse, except when an update ends on that same edge, in which case it stays 1.
- R6: irq is 1 exactly when done_flag is 1, upd_ie is 1 and inhibit is 0. It follows changes of upd_ie and inhibit in the same cycle.
- R7: If inhibit is 1 on the edge that ends the lead period, no cnt_strobe is produced. The update window and the flag setting still proceed.
- R8: A sec_tick pulse that arrives while busy is 1 has no effect: it neither restarts nor extends the sequence, and it adds no extra strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable per 32.768 kHz period |
| sec_tick | input | 1 | One-cycle 1 Hz pulse from the divider |
| upd_ie | input | 1 | Update-interrupt enable |
| inhibit | input | 1 | Transfer inhibit: blocks the strobe and the interrupt |
| flag_clr | input | 1 | One-cycle clear of the update-ended flag |
| busy | output | 1 | Update-in-progress status bit |
| cnt_strobe | output | 1 | One-cycle advance pulse to the time counters |
| done_flag | output | 1 | Sticky update-ended flag |
| irq | output | 1 | Update interrupt request |

## Verification
The sequence is run with regular 1 Hz ticks at a fixed spacing of slow ticks. This pattern separates an off-by-one in the lead or window length from a correct count. Extra sec_tick pulses are injected at random, some during the idle gap and some inside an active cycle. These show the difference between a sequence that is properly locked against restarts and one that re-triggers. The enable, inhibit and clear inputs are changed across segments, including clears that land on the update-ended edge. This separates the sticky, set-priority flag from one that clears too eagerly. It also separates the gated interrupt and suppressed strobe from versions that ignore one of the two gates.

// File: rtl/upd_cycle_pkg.sv
package upd_cycle_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_UPD  = 2'd2
  } phase_e;
endpackage

// File: rtl/upd_cycle_seq.sv
module upd_cycle_seq
  import upd_cycle_pkg::*;
#(
  parameter int LEAD_TICKS = 8,
  parameter int UPD_TICKS  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_tick,
  input  logic sec_tick,
  input  logic inhibit,
  output logic busy,
  output logic cnt_strobe,
  output logic upd_done
);
  localparam int MAXT = (LEAD_TICKS > UPD_TICKS) ? LEAD_TICKS : UPD_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_TICKS - 1);
  localparam logic [CW-1:0] UPD_LAST  = CW'(UPD_TICKS - 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          strobe_d;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    strobe_d = 1'b0;
    upd_done = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (sec_tick) begin
          phase_d = PH_LEAD;
          cnt_d   = '0;
        end
      end
      PH_LEAD: begin
        if (slow_tick) begin
          if (cnt_q == LEAD_LAST) begin
            phase_d  = PH_UPD;
            cnt_d    = '0;
            strobe_d = ~inhibit;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_UPD: begin
        if (slow_tick) begin
          if (cnt_q == UPD_LAST) begin
            phase_d  = PH_IDLE;
            cnt_d    = '0;
            upd_done = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      cnt_strobe <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      cnt_q      <= cnt_d;
      cnt_strobe <= strobe_d;
    end
  end

  assign busy = (phase_q != PH_IDLE);
endmodule

// File: rtl/upd_cycle_flag.sv
module upd_cycle_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_done,
  input  logic flag_clr,
  input  logic upd_ie,
  input  logic inhibit,
  output logic done_flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_flag <= 1'b0;
    else if (upd_done) done_flag <= 1'b1;
    else if (flag_clr) done_flag <= 1'b0;
  end

  assign irq = done_flag & upd_ie & ~inhibit;
endmodule

// File: rtl/upd_cycle_ctl.sv
module upd_cycle_ctl #(
  parameter int LEAD_TICKS = 8,
  parameter int UPD_TICKS  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_tick,
  input  logic sec_tick,
  input  logic upd_ie,
  input  logic inhibit,
  input  logic flag_clr,
  output logic busy,
  output logic cnt_strobe,
  output logic done_flag,
  output logic irq
);
  logic upd_done;

  upd_cycle_seq #(
    .LEAD_TICKS(LEAD_TICKS),
    .UPD_TICKS (UPD_TICKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .sec_tick  (sec_tick),
    .inhibit   (inhibit),
    .busy      (busy),
    .cnt_strobe(cnt_strobe),
    .upd_done  (upd_done)
  );

  upd_cycle_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_done (upd_done),
    .flag_clr (flag_clr),
    .upd_ie   (upd_ie),
    .inhibit  (inhibit),
    .done_flag(done_flag),
    .irq      (irq)
  );
endmodule

// File: rtl/upd_cycle_ctl_chk.sv
module upd_cycle_ctl_chk #(
  parameter int LEAD_TICKS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic slow_tick,
  input logic inhibit,
  input logic flag_clr,
  input logic busy,
  input logic cnt_strobe,
  input logic done_flag
);
  localparam int CW = $clog2(LEAD_TICKS + 2);
  logic [CW-1:0] lead_seen;
  logic          struck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_seen <= '0;
      struck    <= 1'b0;
    end else if (!busy) begin
      lead_seen <= '0;
      struck    <= 1'b0;
    end else begin
      if (slow_tick && !struck && lead_seen < CW'(LEAD_TICKS)) lead_seen <= lead_seen + 1'b1;
      if (cnt_strobe) struck <= 1'b1;
    end
  end

  // R3: the strobe lands inside the busy window after exactly the lead count
  a_r3_strobe_after_lead: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_strobe |-> (busy && lead_seen == CW'(LEAD_TICKS)));

  // R3: the strobe is a single-cycle pulse
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_strobe |=> !cnt_strobe);

  // R4: the flag only rises as busy drops
  a_r4_flag_with_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $fell(busy));

  // R5: the flag holds without a clear
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);

  // R7: no strobe follows an inhibited edge
  a_r7_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_strobe |-> !$past(inhibit));
endmodule

bind upd_cycle_ctl upd_cycle_ctl_chk #(.LEAD_TICKS(LEAD_TICKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slow_tick (slow_tick),
  .inhibit   (inhibit),
  .flag_clr  (flag_clr),
  .busy      (busy),
  .cnt_strobe(cnt_strobe),
  .done_flag (done_flag)
);

// File: tb/upd_cycle_ctl_bench.sv
`timescale 1ns/1ps
module upd_cycle_ctl_bench;
  localparam int LEAD = 4;
  localparam int UPD  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0, sec_tick = 1'b0, upd_ie = 1'b0, inhibit = 1'b0, flag_clr = 1'b0;
  logic busy, cnt_strobe, done_flag, irq;

  always #4 clk = ~clk;

  upd_cycle_ctl #(.LEAD_TICKS(LEAD), .UPD_TICKS(UPD)) u_upd_cycle_ctl (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sec_tick(sec_tick),
    .upd_ie(upd_ie), .inhibit(inhibit), .flag_clr(flag_clr),
    .busy(busy), .cnt_strobe(cnt_strobe), .done_flag(done_flag), .irq(irq));

  int total = 0, bad = 0, cyc = 0;
  // reference model state
  int ph = 0, n = 0;
  bit m_strobe = 0, m_flag = 0, m_done = 0;
  bit prev_sec_idle = 0, prev_busy = 0;
  int strobes_seen = 0, strobes_exp = 0, ignored_secs = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", req, cyc, act, exp);
    end
  endtask

  // reference model advances on each rising edge using the settled inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; n = 0; m_strobe = 0; m_flag = 0; m_done = 0; prev_sec_idle = 0;
    end else begin
      m_done = 0; m_strobe = 0;
      prev_sec_idle = (ph == 0) && sec_tick;
      if (ph != 0 && sec_tick) ignored_secs++;
      if (ph == 0) begin
        if (sec_tick) begin ph = 1; n = 0; end
      end else if (ph == 1) begin
        if (slow_tick) begin
          n++;
          if (n == LEAD) begin
            ph = 2; n = 0; m_strobe = !inhibit;
            if (!inhibit) strobes_exp++;
          end
        end
      end else begin
        if (slow_tick) begin
          n++;
          if (n == UPD) begin ph = 0; n = 0; m_done = 1; end
        end
      end
      if (m_done) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
  end

  initial begin
    int seg;
    int gap;
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    chk("R1", busy, 1'b0); chk("R1", cnt_strobe, 1'b0);
    chk("R1", done_flag, 1'b0); chk("R1", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", busy, 1'b0); chk("R1", done_flag, 1'b0);
    gap = 0;
    for (int c = 0; c < 8000; c++) begin
      cyc = c;
      seg = c / 1000;
      // compare against the model before driving new inputs
      chk("R3", busy, (ph != 0));
      chk("R7", cnt_strobe, m_strobe);
      chk("R5", done_flag, m_flag);
      chk("R6", irq, m_flag && upd_ie && !inhibit);
      if (prev_sec_idle) chk("R2", busy, 1'b1);
      if (prev_busy && !busy) chk("R4", done_flag, 1'b1);
      if (cnt_strobe) strobes_seen++;
      prev_busy = busy;
      // new stimulus
      slow_tick = (c % 3 == 0);
      gap++;
      sec_tick = 1'b0;
      if (gap >= 90) begin sec_tick = 1'b1; gap = 0; end
      else if ($urandom_range(0, 29) == 0) sec_tick = 1'b1;
      upd_ie   = (seg % 2 == 1) || (seg >= 6 && $urandom_range(0, 1) == 1);
      inhibit  = (seg == 2 || seg == 3) ? 1'b1 :
                 (seg >= 4 && $urandom_range(0, 3) == 0);
      flag_clr = (seg == 5) ? (busy && $urandom_range(0, 1) == 1)
                            : ($urandom_range(0, 19) == 0);
      @(negedge clk);
    end
    // R8: surplus ticks must not have produced extra strobes
    total++;
    if (strobes_seen != strobes_exp || ignored_secs == 0) begin
      bad++;
      $display("FAIL R8: strobes actual=%0d expected=%0d (ignored ticks %0d)",
               strobes_seen, strobes_exp, ignored_secs);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule